// File: doc/BRIEF.md
# Interrupt Source Masking and Routing Register Bank

This block sits between a set of interrupt request lines and the processor's two interrupt inputs. Each source is active when its hardware line is high or when software has raised a request bit for it. A per-source routing bit sends that source either to the normal interrupt path or to the fast interrupt path. The normal path is further gated by a per-source enable bit. The fast path has no enable, and any routed source asserts it at once.

The masked normal-path vector is also brought out for a downstream priority resolver. Software reads and writes the bank through a simple word-addressed bus. Read data appears on the cycle after the read strobe. Enable and software-request bits are never rewritten whole. Each has a set-only location and a clear-only location, so concurrent handlers need no read-modify-write. A fixed run of identification bytes and a stored protection flag complete the bank.

Top module: `irqm_bank`

## Requirements
- R1: Word 2 reads the raw request vector, which is the bitwise OR of the hardware input lines and the software request bits.
- R2: Word 0 reads the normal-path status, raw AND enable AND NOT route. `irq_vec` carries the same vector continuously, and `irq_o` is high when any bit of it is set.
- R3: Word 1 reads the fast-path status, raw AND route, with no enable applied. `fiq_o` is high when any bit of it is set, whatever the enables hold.
- R4: Writing word 4 ORs the data into the enable vector, which reads back at word 4. Writing word 5 clears every enable bit written as one and leaves the others alone.
- R5: Writing word 6 ORs the data into the software request vector, which reads back at word 6. Writing word 7 clears every software request bit written as one.
- R6: Word 3 is the route vector, which is fully replaced by a write and read back unchanged. A bit value of 1 routes that source to the fast path.
- R7: Word 8 stores bit 0 of the write data as a protection flag. It reads back in bit 0 with all other bits zero, and it affects nothing else.
- R8: A write to word 0 changes no stored state.
- R9: Words 0x3F8 through 0x3FF (byte offsets 0xFE0 to 0xFFC) read, in ascending address order, the constant bytes 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits 7:0.
- R10: After reset, the enable, route, software request and protection registers all read zero.
- R11: A read of any unlisted word returns zero, and a write to one changes no stored state.
- R12: `bus_rdata` holds the read value in the cycle after a `bus_rd` strobe and is zero after a cycle without one. A read in the same cycle as a write returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_req | input | NUM_SRC | Hardware request levels |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_vec | output | NUM_SRC | Masked normal-path status vector |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with 32 sources, a 32-bit data path and a 10-bit word address. At these sizes every source bit maps one to one onto a data bit. The identification words at the top of the 4 KiB window are reachable, as are unmapped words both below and between the mapped ones. A behavioural model of the bank is compared on every clock against the read data and the three interrupt outputs. Directed sequences for set/clear, routing and same-cycle read/write are followed by a pseudo-random mix of accesses and hardware patterns.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

    localparam int WORD_IRQ_STAT = 0;
    localparam int WORD_FIQ_STAT = 1;
    localparam int WORD_RAW      = 2;
    localparam int WORD_ROUTE    = 3;
    localparam int WORD_EN_SET   = 4;
    localparam int WORD_EN_CLR   = 5;
    localparam int WORD_SW_SET   = 6;
    localparam int WORD_SW_CLR   = 7;
    localparam int WORD_PROT     = 8;
    localparam int WORD_ID_BASE  = 'h3F8;
    localparam int ID_WORDS      = 8;

    typedef enum logic [2:0] {
        WOP_NONE,
        WOP_ROUTE,
        WOP_EN_SET,
        WOP_EN_CLR,
        WOP_SW_SET,
        WOP_SW_CLR,
        WOP_PROT
    } wr_op_e;

    typedef enum logic [3:0] {
        RSEL_ZERO,
        RSEL_IRQ,
        RSEL_FIQ,
        RSEL_RAW,
        RSEL_ROUTE,
        RSEL_EN,
        RSEL_SW,
        RSEL_PROT,
        RSEL_ID
    } rd_sel_e;

    // Identification byte for a given word within the ID window.
    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h90;
            3'd1:    b = 8'h11;
            3'd2:    b = 8'h04;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/irqm_decode.sv
module irqm_decode
    import irqm_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              id_hit,
    output wr_op_e            wr_op,
    output rd_sel_e           rd_sel
);

    always_comb begin
        wr_op = WOP_NONE;
        if (wr) begin
            if (addr == ADDR_W'(WORD_ROUTE))       wr_op = WOP_ROUTE;
            else if (addr == ADDR_W'(WORD_EN_SET)) wr_op = WOP_EN_SET;
            else if (addr == ADDR_W'(WORD_EN_CLR)) wr_op = WOP_EN_CLR;
            else if (addr == ADDR_W'(WORD_SW_SET)) wr_op = WOP_SW_SET;
            else if (addr == ADDR_W'(WORD_SW_CLR)) wr_op = WOP_SW_CLR;
            else if (addr == ADDR_W'(WORD_PROT))   wr_op = WOP_PROT;
            // status word and unmapped words: no write effect
        end
    end

    always_comb begin
        rd_sel = RSEL_ZERO;
        if (id_hit)                              rd_sel = RSEL_ID;
        else if (addr == ADDR_W'(WORD_IRQ_STAT)) rd_sel = RSEL_IRQ;
        else if (addr == ADDR_W'(WORD_FIQ_STAT)) rd_sel = RSEL_FIQ;
        else if (addr == ADDR_W'(WORD_RAW))      rd_sel = RSEL_RAW;
        else if (addr == ADDR_W'(WORD_ROUTE))    rd_sel = RSEL_ROUTE;
        else if (addr == ADDR_W'(WORD_EN_SET))   rd_sel = RSEL_EN;
        else if (addr == ADDR_W'(WORD_SW_SET))   rd_sel = RSEL_SW;
        else if (addr == ADDR_W'(WORD_PROT))     rd_sel = RSEL_PROT;
    end

endmodule

// File: rtl/irqm_idrom.sv
module irqm_idrom
    import irqm_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [7:0]        data
);

    localparam int IDX_W = $clog2(ID_WORDS);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(WORD_ID_BASE);

    assign hit  = (addr[ADDR_W-1:IDX_W] == BASE[ADDR_W-1:IDX_W]);
    assign data = id_byte(addr[IDX_W-1:0]);

endmodule

// File: rtl/irqm_route.sv
module irqm_route #(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0] hw,
    input  logic [NUM_SRC-1:0] sw,
    input  logic [NUM_SRC-1:0] en,
    input  logic [NUM_SRC-1:0] route,
    output logic [NUM_SRC-1:0] raw,
    output logic [NUM_SRC-1:0] irq_stat,
    output logic [NUM_SRC-1:0] fiq_stat
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign raw[i]      = hw[i] | sw[i];
        assign irq_stat[i] = raw[i] & en[i] & ~route[i];
        assign fiq_stat[i] = raw[i] & route[i];
    end

endmodule

// File: rtl/irqm_bank.sv
module irqm_bank
    import irqm_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] hw_req,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_SRC-1:0] irq_vec,
    output logic               irq_o,
    output logic               fiq_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] route;
        logic [NUM_SRC-1:0] sw;
        logic               prot;
        logic [DATA_W-1:0]  rdata;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_SRC-1:0] en_q, route_q, sw_q;
    logic               prot_q;
    logic [NUM_SRC-1:0] raw, irq_stat, fiq_stat;
    logic               id_hit;
    logic [7:0]         id_data;
    wr_op_e             wr_op;
    rd_sel_e            rd_sel;
    logic [DATA_W-1:0]  rd_val;

    assign en_q    = state_q.en;
    assign route_q = state_q.route;
    assign sw_q    = state_q.sw;
    assign prot_q  = state_q.prot;

    irqm_idrom #(.ADDR_W(ADDR_W)) u_idrom (
        .addr (bus_addr),
        .hit  (id_hit),
        .data (id_data)
    );

    irqm_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr     (bus_wr),
        .addr   (bus_addr),
        .id_hit (id_hit),
        .wr_op  (wr_op),
        .rd_sel (rd_sel)
    );

    irqm_route #(.NUM_SRC(NUM_SRC)) u_route (
        .hw       (hw_req),
        .sw       (sw_q),
        .en       (en_q),
        .route    (route_q),
        .raw      (raw),
        .irq_stat (irq_stat),
        .fiq_stat (fiq_stat)
    );

    // Read multiplexer sees state before any write in the same cycle.
    always_comb begin
        case (rd_sel)
            RSEL_IRQ:   rd_val = DATA_W'(irq_stat);
            RSEL_FIQ:   rd_val = DATA_W'(fiq_stat);
            RSEL_RAW:   rd_val = DATA_W'(raw);
            RSEL_ROUTE: rd_val = DATA_W'(route_q);
            RSEL_EN:    rd_val = DATA_W'(en_q);
            RSEL_SW:    rd_val = DATA_W'(sw_q);
            RSEL_PROT:  rd_val = DATA_W'(prot_q);
            RSEL_ID:    rd_val = DATA_W'(id_data);
            default:    rd_val = '0;
        endcase
    end

    always_comb begin
        logic [NUM_SRC-1:0] wv;
        wv      = bus_wdata[NUM_SRC-1:0];
        state_d = state_q;
        case (wr_op)
            WOP_ROUTE:  state_d.route = wv;
            WOP_EN_SET: state_d.en    = state_q.en | wv;
            WOP_EN_CLR: state_d.en    = state_q.en & ~wv;
            WOP_SW_SET: state_d.sw    = state_q.sw | wv;
            WOP_SW_CLR: state_d.sw    = state_q.sw & ~wv;
            WOP_PROT:   state_d.prot  = bus_wdata[0];
            default:    ;
        endcase
        state_d.rdata = bus_rd ? rd_val : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign bus_rdata = state_q.rdata;
    assign irq_vec   = irq_stat;
    assign irq_o     = |irq_stat;
    assign fiq_o     = |fiq_stat;

endmodule

// File: rtl/irqm_bank_chk.sv
module irqm_bank_chk #(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] hw_req,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_SRC-1:0] irq_vec,
    input logic               fiq_o,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] route_q,
    input logic [NUM_SRC-1:0] sw_q,
    input logic               prot_q
);

    AST_ROUTED_NOT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vec & route_q) == '0); // R2

    AST_FIQ_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_req & route_q) != '0) |-> fiq_o); // R3

    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(4)) |=>
        ((en_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0]))); // R4

    AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(5)) |=>
        ((en_q & $past(bus_wdata[NUM_SRC-1:0])) == '0)); // R4

    AST_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(6)) |=>
        ((sw_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0]))); // R5

    AST_SW_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(7)) |=>
        ((sw_q & $past(bus_wdata[NUM_SRC-1:0])) == '0)); // R5

    AST_PROT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(8)) |=> (prot_q == $past(bus_wdata[0]))); // R7

    AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(0)) |=>
        ($stable(en_q) && $stable(route_q) && $stable(sw_q) && $stable(prot_q))); // R8

    AST_ID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'('h3F8)) |=> (bus_rdata == DATA_W'('h90))); // R9

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0)); // R12

endmodule

bind irqm_bank irqm_bank_chk #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_req    (hw_req),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_vec   (irq_vec),
    .fiq_o     (fiq_o),
    .en_q      (en_q),
    .route_q   (route_q),
    .sw_q      (sw_q),
    .prot_q    (prot_q)
);

// File: tb/irqm_bank_test.sv
`timescale 1ns/1ps
module irqm_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] hw_req = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_vec;
    logic        irq_o;
    logic        fiq_o;

    int checks = 0;
    int errors = 0;

    // behavioural model state
    logic [31:0] m_en = '0, m_route = '0, m_sw = '0;
    logic        m_prot = 1'b0;

    always #2.5 clk = ~clk;

    irqm_bank #(.NUM_SRC(32), .DATA_W(32), .ADDR_W(10)) uut (
        .clk (clk), .rst_n (rst_n), .hw_req (hw_req),
        .bus_rd (bus_rd), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .irq_vec (irq_vec), .irq_o (irq_o), .fiq_o (fiq_o)
    );

    function automatic logic [31:0] model_read(input logic [9:0] a, input logic [31:0] hw);
        logic [31:0] raw;
        raw = hw | m_sw;
        if (a >= 10'h3F8) begin
            case (a - 10'h3F8)
                10'd0: return 32'h90;
                10'd1: return 32'h11;
                10'd2: return 32'h04;
                10'd3: return 32'h00;
                10'd4: return 32'h0D;
                10'd5: return 32'hF0;
                10'd6: return 32'h05;
                default: return 32'hB1;
            endcase
        end
        case (a)
            10'd0: return raw & m_en & ~m_route;
            10'd1: return raw & m_route;
            10'd2: return raw;
            10'd3: return m_route;
            10'd4: return m_en;
            10'd6: return m_sw;
            10'd8: return {31'd0, m_prot};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [9:0] a);
        if (a >= 10'h3F8) return "R9";
        case (a)
            10'd0: return "R2";
            10'd1: return "R3";
            10'd2: return "R1";
            10'd3: return "R6";
            10'd4: return "R4";
            10'd6: return "R5";
            10'd8: return "R7";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, update model, compare after posedge.
    task automatic step(input logic wr, input logic rd, input logic [9:0] a,
                        input logic [31:0] wd, input logic [31:0] hw, input string rtag);
        logic [31:0] exp_rd;
        logic [31:0] exp_irq;
        logic [31:0] exp_fiq;
        string t;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd; hw_req = hw;
        exp_rd = rd ? model_read(a, hw) : 32'd0;   // R12: old value on same-cycle write
        if (wr) begin
            case (a)
                10'd3: m_route = wd;
                10'd4: m_en = m_en | wd;
                10'd5: m_en = m_en & ~wd;
                10'd6: m_sw = m_sw | wd;
                10'd7: m_sw = m_sw & ~wd;
                10'd8: m_prot = wd[0];
                default: ; // R8 status word, R11 unmapped: no effect
            endcase
        end
        @(posedge clk);
        #1;
        t = (rtag != "") ? rtag : (rd ? tag_of(a) : "R12");
        check(t, "rdata", bus_rdata, exp_rd);
        exp_irq = (hw | m_sw) & m_en & ~m_route;
        exp_fiq = (hw | m_sw) & m_route;
        check("R2", "irq_vec", irq_vec, exp_irq);
        check("R2", "irq_o", {31'd0, irq_o}, {31'd0, |exp_irq});
        check("R3", "fiq_o", {31'd0, fiq_o}, {31'd0, |exp_fiq});
    endtask

    task automatic rd(input logic [9:0] a, input logic [31:0] hw, input string t);
        step(1'b0, 1'b1, a, 32'd0, hw, t);
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d, input logic [31:0] hw);
        step(1'b1, 1'b0, a, d, hw, "");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] xs;
        xs = 32'h1234_5678;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        rd(10'd3, '0, "R10");
        rd(10'd4, '0, "R10");
        rd(10'd6, '0, "R10");
        rd(10'd8, '0, "R10");
        rd(10'd0, '0, "R10");
        rd(10'd2, '0, "R10");

        // R4 enable set / clear
        wr(10'd4, 32'hFFFF_0000, '0);
        rd(10'd4, '0, "R4");
        wr(10'd5, 32'h0F00_0000, '0);
        rd(10'd4, '0, "R4");
        wr(10'd4, 32'h0000_00F0, '0);
        rd(10'd4, '0, "R4");

        // R6 routing, R1/R2/R3 status views
        wr(10'd3, 32'h00FF_00FF, '0);
        rd(10'd3, '0, "R6");
        rd(10'd0, 32'hA5A5_A5A5, "R2");
        rd(10'd1, 32'hA5A5_A5A5, "R3");
        rd(10'd2, 32'hA5A5_A5A5, "R1");

        // R5 software requests
        wr(10'd6, 32'h0000_0F0F, '0);
        rd(10'd6, '0, "R5");
        wr(10'd7, 32'h0000_0003, '0);
        rd(10'd6, '0, "R5");
        rd(10'd2, 32'h8000_0000, "R1");

        // R3 fast path ignores enables
        wr(10'd5, 32'hFFFF_FFFF, '0);
        rd(10'd1, 32'h0000_0010, "R3");
        rd(10'd0, 32'h0000_0010, "R2");

        // R7 protection flag
        wr(10'd8, 32'hFFFF_FFFF, '0);
        rd(10'd8, '0, "R7");
        wr(10'd8, 32'h0000_0002, '0);
        rd(10'd8, '0, "R7");

        // R8 write to status word
        wr(10'd4, 32'h1234_0000, '0);
        wr(10'd0, 32'hFFFF_FFFF, '0);
        rd(10'd3, '0, "R8");
        rd(10'd4, '0, "R8");
        rd(10'd6, '0, "R8");
        rd(10'd8, '0, "R8");

        // R9 identification words
        for (int k = 0; k < 8; k++) rd(10'h3F8 + 10'(k), '0, "R9");

        // R11 unmapped reads and writes
        rd(10'd9, '0, "R11");
        rd(10'h100, '0, "R11");
        rd(10'h3F7, '0, "R11");
        wr(10'd9, 32'hFFFF_FFFF, '0);
        wr(10'h200, 32'hFFFF_FFFF, '0);
        rd(10'd3, '0, "R11");
        rd(10'd4, '0, "R11");
        rd(10'd6, '0, "R11");

        // R12 same-cycle read and write returns the old value
        step(1'b1, 1'b1, 10'd4, 32'h0000_000F, '0, "R12");
        rd(10'd4, '0, "R12");
        step(1'b1, 1'b1, 10'd3, 32'h0, '0, "R12");

        // mixed pseudo-random traffic
        for (int n = 0; n < 400; n++) begin
            logic [9:0] a;
            logic [31:0] d, h;
            xs = xs ^ (xs << 13); xs = xs ^ (xs >> 17); xs = xs ^ (xs << 5);
            d = xs;
            xs = xs ^ (xs << 13); xs = xs ^ (xs >> 17); xs = xs ^ (xs << 5);
            h = xs & 32'h0F0F_F0F0;
            case (xs[27:24])
                4'd9:  a = 10'd11;
                4'd10: a = 10'h3F8 + 10'(xs[2:0]);
                4'd11: a = 10'h3FC;
                4'd12: a = 10'd3;
                default: a = 10'(xs[27:24]);
            endcase
            step(xs[30], xs[31], a, d, h, "");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule